// File: doc/BRIEF.md
# Software Interrupt Acceptance Filter

This block decides whether a request to raise one of sixteen software-generated interrupts on a processor may set that interrupt's pending bit. Each request carries an interrupt number, the group the requester asks for, and a flag that says whether the requester is non-secure. The block compares the request with the group configured for the target interrupt. A per-interrupt two-bit permission level, packed into a 32-bit access-control word, limits what non-secure requesters may raise. A global input turns security off, and while it is set the permission levels are ignored.

An accepted request produces a one-hot pulse on the pending-set output one clock after the request is presented. The pulse is meant to drive the set inputs of a pending register that lives elsewhere. A rejected request produces nothing and gives no indication. The block does not store pending state and does not route requests between processors.

Top module: `sgi_accept_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no request presented, `pend_set` is all zeros.
- R2: The outcome of a request presented with `req_valid` high at a rising clock edge appears on `pend_set` for exactly the following cycle. In any cycle that follows an edge with `req_valid` low, `pend_set` is zero.
- R3: The permission level of interrupt n is bits [2n+1:2n] of `ns_acc`.
- R4: Permission levels are consulted only when `req_ns` is 1 and `sec_off` is 0. A secure request, or any request while `sec_off` is 1, is accepted whenever the group rule passes.
- R5: A non-secure request, with security on, whose target is configured as group 0 (code 0) is accepted only if the target's permission level is 1 or more.
- R6: A non-secure request, with security on, whose target is configured as secure group 1 (code 1) is accepted only if the target's permission level is 2 or more.
- R7: A request whose target is configured as non-secure group 1 (code 2) and whose requested group is also code 2 is accepted whatever the permission level.
- R8: A request for secure group 1 (code 1) whose target is configured as group 0 (code 0) passes the group rule and is then judged as a group-0 request. For a non-secure requester with security on, this means the permission level must be at least 1.
- R9: Apart from the case in R8, a request whose requested group differs from the target's configured group is dropped. A request in which either group is the unused code 3 is also dropped.
- R10: An accepted request sets exactly one bit of `pend_set`: bit `req_sgi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_sgi | input | 4 | Target interrupt number |
| req_grp | input | 2 | Requested group: 0 group 0, 1 secure group 1, 2 non-secure group 1, 3 unused |
| req_ns | input | 1 | Requester is non-secure |
| tgt_grp | input | 2 | Configured group of the target interrupt, same coding as `req_grp` |
| ns_acc | input | 32 | Permission word, two bits per interrupt |
| sec_off | input | 1 | Security disabled globally |
| pend_set | output | 16 | One-hot pending-set pulse |

## Verification
The bench sweeps the permission level of a single interrupt through all four values for group-0 and secure group-1 targets. A filter that compares levels with the wrong threshold, or with an off-by-one, would accept level 0 for group 0 or level 1 for secure group 1. It varies the target number while keeping the level field of its neighbours different, so a filter that picks the wrong field of the permission word would accept or drop the wrong requests. It also covers the secure group-1 request aimed at a group-0 target, which a filter that demands strict group equality would drop. It sets `sec_off` and sends secure requests with zero permission levels, which a filter that checks levels unconditionally would refuse.

// File: rtl/sgi_filt_pkg.sv
package sgi_filt_pkg;
  // group coding shared by requested and configured groups
  typedef enum logic [1:0] {
    GRP_ZERO  = 2'd0,
    GRP_ONE_S = 2'd1,
    GRP_ONE_N = 2'd2,
    GRP_BAD   = 2'd3
  } grp_e;

  // minimum permission level a non-secure requester needs per target group
  localparam int unsigned MIN_LVL_ZERO  = 1;
  localparam int unsigned MIN_LVL_ONE_S = 2;
endpackage

// File: rtl/sgi_perm_pick.sv
module sgi_perm_pick #(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned FLD_W   = 2,
  localparam int unsigned ID_W   = $clog2(NUM_SGI),
  localparam int unsigned ACC_W  = NUM_SGI * FLD_W
) (
  input  logic [ACC_W-1:0] acc_word,
  input  logic [ID_W-1:0]  sel,
  output logic [FLD_W-1:0] level
);
  logic [FLD_W-1:0] fields [NUM_SGI];

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_fld
    assign fields[g] = acc_word[g*FLD_W +: FLD_W];
  end

  assign level = fields[sel];
endmodule

// File: rtl/sgi_group_gate.sv
module sgi_group_gate
  import sgi_filt_pkg::*;
(
  input  logic [1:0] req_grp,
  input  logic [1:0] tgt_grp,
  output logic       grp_ok
);
  logic [1:0] eff_grp;

  always_comb begin
    // secure group-1 request landing on a group-0 target is treated as group 0
    if (req_grp == GRP_ONE_S && tgt_grp == GRP_ZERO) begin
      eff_grp = GRP_ZERO;
    end else begin
      eff_grp = req_grp;
    end
    grp_ok = (eff_grp == tgt_grp) && (tgt_grp != GRP_BAD);
  end
endmodule

// File: rtl/sgi_level_gate.sv
module sgi_level_gate
  import sgi_filt_pkg::*;
#(
  parameter int unsigned FLD_W = 2
) (
  input  logic             req_ns,
  input  logic             sec_off,
  input  logic [1:0]       tgt_grp,
  input  logic [FLD_W-1:0] level,
  output logic             lvl_ok
);
  logic checked;

  always_comb begin
    checked = req_ns && !sec_off;
    lvl_ok  = 1'b1;
    if (checked) begin
      unique case (tgt_grp)
        GRP_ZERO:  lvl_ok = (level >= FLD_W'(MIN_LVL_ZERO));
        GRP_ONE_S: lvl_ok = (level >= FLD_W'(MIN_LVL_ONE_S));
        default:   lvl_ok = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sgi_pend_pulse.sv
module sgi_pend_pulse #(
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned ID_W   = $clog2(NUM_SGI)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [ID_W-1:0]    sel,
  output logic [NUM_SGI-1:0] pend_set
);
  logic [NUM_SGI-1:0] pend_d;
  logic [NUM_SGI-1:0] pend_q;
  logic               pend_en;

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_dec
    assign pend_d[g] = accept && (sel == ID_W'(g));
  end

  // load when a new pulse starts or an old one must end
  assign pend_en = accept || (pend_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_set = pend_q;
endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter #(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned FLD_W   = 2,
  localparam int unsigned ID_W   = $clog2(NUM_SGI),
  localparam int unsigned ACC_W  = NUM_SGI * FLD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ID_W-1:0]    req_sgi,
  input  logic [1:0]         req_grp,
  input  logic               req_ns,
  input  logic [1:0]         tgt_grp,
  input  logic [ACC_W-1:0]   ns_acc,
  input  logic               sec_off,
  output logic [NUM_SGI-1:0] pend_set
);
  logic [FLD_W-1:0] level;
  logic             grp_ok;
  logic             lvl_ok;
  logic             accept;

  sgi_perm_pick #(.NUM_SGI(NUM_SGI), .FLD_W(FLD_W)) u_pick (
    .acc_word (ns_acc),
    .sel      (req_sgi),
    .level    (level)
  );

  sgi_group_gate u_grp (
    .req_grp (req_grp),
    .tgt_grp (tgt_grp),
    .grp_ok  (grp_ok)
  );

  sgi_level_gate #(.FLD_W(FLD_W)) u_lvl (
    .req_ns  (req_ns),
    .sec_off (sec_off),
    .tgt_grp (tgt_grp),
    .level   (level),
    .lvl_ok  (lvl_ok)
  );

  assign accept = req_valid && grp_ok && lvl_ok;

  sgi_pend_pulse #(.NUM_SGI(NUM_SGI)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .sel      (req_sgi),
    .pend_set (pend_set)
  );
endmodule

// File: rtl/sgi_accept_filter_chk.sv
module sgi_accept_filter_chk #(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned FLD_W   = 2,
  localparam int unsigned ID_W   = $clog2(NUM_SGI),
  localparam int unsigned ACC_W  = NUM_SGI * FLD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [ID_W-1:0]    req_sgi,
  input logic [1:0]         req_grp,
  input logic               req_ns,
  input logic [1:0]         tgt_grp,
  input logic [ACC_W-1:0]   ns_acc,
  input logic               sec_off,
  input logic [NUM_SGI-1:0] pend_set
);
  logic [FLD_W-1:0] fld;
  logic             guarded;
  assign fld     = ns_acc[req_sgi*FLD_W +: FLD_W];
  assign guarded = req_valid && req_ns && !sec_off;

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (pend_set == '0);
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> pend_set == '0);

  assert_g0_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (guarded && tgt_grp == 2'd0 && fld == '0) |=> pend_set == '0);

  assert_g1s_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (guarded && tgt_grp == 2'd1 && fld < FLD_W'(2)) |=> pend_set == '0);

  assert_ns_grp_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grp == 2'd2 && tgt_grp == 2'd2)
      |=> pend_set == (NUM_SGI'(1) << $past(req_sgi)));

  assert_secure_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!req_ns || sec_off) && req_grp == tgt_grp && tgt_grp != 2'd3)
      |=> pend_set != '0);

  assert_mismatch_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grp != tgt_grp && !(req_grp == 2'd1 && tgt_grp == 2'd0))
      |=> pend_set == '0);

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_set));
endmodule

bind sgi_accept_filter sgi_accept_filter_chk #(.NUM_SGI(NUM_SGI), .FLD_W(FLD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_sgi   (req_sgi),
  .req_grp   (req_grp),
  .req_ns    (req_ns),
  .tgt_grp   (tgt_grp),
  .ns_acc    (ns_acc),
  .sec_off   (sec_off),
  .pend_set  (pend_set)
);

// File: tb/sim_sgi_accept_filter.sv
module sim_sgi_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_sgi;
  logic [1:0]  req_grp;
  logic        req_ns;
  logic [1:0]  tgt_grp;
  logic [31:0] ns_acc;
  logic        sec_off;
  logic [15:0] pend_set;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sgi_accept_filter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sgi(req_sgi),
    .req_grp(req_grp), .req_ns(req_ns), .tgt_grp(tgt_grp), .ns_acc(ns_acc),
    .sec_off(sec_off), .pend_set(pend_set)
  );

  // behavioural expectation straight from the requirement list
  function automatic logic [15:0] model(input logic v, input int num, input int rg,
                                        input logic ns, input int tg,
                                        input logic [31:0] acc, input logic off);
    int lvl;
    int want;
    if (!v) return 16'h0;
    if (rg == 3 || tg == 3) return 16'h0;
    if (!(rg == tg || (rg == 1 && tg == 0))) return 16'h0;
    lvl  = (acc >> (2 * num)) % 4;
    want = 0;
    if (ns && !off) begin
      if (tg == 0) want = 1;
      if (tg == 1) want = 2;
    end
    if (lvl < want) return 16'h0;
    return 16'h1 << num;
  endfunction

  task automatic compare(input string tag, input logic [15:0] exp);
    n_cmp++;
    if (pend_set !== exp) begin
      n_bad++;
      $display("FAIL %s: pend_set=%h expected=%h", tag, pend_set, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(input string tag, input logic v, input int num, input int rg,
                      input logic ns, input int tg, input logic [31:0] acc,
                      input logic off);
    logic [15:0] e;
    req_valid = v; req_sgi = 4'(num); req_grp = 2'(rg);
    req_ns = ns; tgt_grp = 2'(tg); ns_acc = acc; sec_off = off;
    e = model(v, num, rg, ns, tg, acc, off);
    @(negedge clk);
    compare(tag, e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] acc;
    rst_n = 1'b0; req_valid = 1'b0; req_sgi = '0; req_grp = '0;
    req_ns = 1'b0; tgt_grp = '0; ns_acc = '0; sec_off = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset", 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release", 16'h0);

    // R2: pulse lasts one cycle, idle afterwards
    step("R2 accept", 1'b1, 5, 2, 1'b1, 2, 32'h0, 1'b0);
    step("R2 idle after", 1'b0, 5, 2, 1'b1, 2, 32'h0, 1'b0);

    // R5 / R3: sweep level of interrupt 7 for a group-0 target, neighbours differ
    for (int l = 0; l < 4; l++) begin
      acc = 32'hFFFF_FFFF;
      acc[15:14] = 2'(l);
      acc[13:12] = 2'd0;
      step("R5 g0 level sweep", 1'b1, 7, 0, 1'b1, 0, acc, 1'b0);
    end
    // R6: same sweep for secure group 1
    for (int l = 0; l < 4; l++) begin
      acc = 32'h0;
      acc[7:6] = 2'(l);
      acc[9:8] = 2'd3;
      step("R6 g1s level sweep", 1'b1, 3, 1, 1'b1, 1, acc, 1'b0);
    end
    // R3: field position, each interrupt with only its own field set
    for (int n = 0; n < 16; n++) begin
      step("R3 own field", 1'b1, n, 1, 1'b1, 1, 32'h2 << (2 * n), 1'b0);
      step("R3 other field", 1'b1, n, 1, 1'b1, 1, ~(32'h3 << (2 * n)), 1'b0);
    end
    // R4: secure requester and security off ignore levels
    step("R4 secure g0", 1'b1, 9, 0, 1'b0, 0, 32'h0, 1'b0);
    step("R4 sec_off g1s", 1'b1, 9, 1, 1'b1, 1, 32'h0, 1'b1);
    // R7: non-secure group 1 needs nothing
    step("R7 ns g1", 1'b1, 15, 2, 1'b1, 2, 32'h0, 1'b0);
    // R8: secure-group-1 request on group-0 target
    step("R8 secure", 1'b1, 2, 1, 1'b0, 0, 32'h0, 1'b0);
    step("R8 ns lvl0", 1'b1, 2, 1, 1'b1, 0, 32'h0, 1'b0);
    step("R8 ns lvl1", 1'b1, 2, 1, 1'b1, 0, 32'h10, 1'b0);
    // R9: mismatches and the unused code
    step("R9 g0 on g1s", 1'b1, 4, 0, 1'b0, 1, 32'hFFFF_FFFF, 1'b0);
    step("R9 g1n on g0", 1'b1, 4, 2, 1'b0, 0, 32'hFFFF_FFFF, 1'b1);
    step("R9 code3", 1'b1, 4, 3, 1'b0, 3, 32'hFFFF_FFFF, 1'b1);
    // R10: back-to-back accepts on distinct targets
    for (int n = 0; n < 16; n++)
      step("R10 back to back", 1'b1, n, 2, 1'b0, 2, 32'h0, 1'b0);

    // R2: mixed random traffic compared every clock
    for (int i = 0; i < 3000; i++)
      step("R2 random", 1'($urandom), int'($urandom % 16), int'($urandom % 4),
           1'($urandom), int'($urandom % 4), $urandom, 1'(($urandom % 4) == 0));

    step("R2 final idle", 1'b0, 0, 0, 1'b0, 0, 32'h0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule